// File: doc/BRIEF.md
# Variable-length coefficient encoder

The block turns a stream of small signed transform coefficients into a prefix-free variable-length bit code and packs the resulting bit stream into bytes. Every coefficient accepted on the valid/ready input is mapped through a fixed code table. The short codes cover the values that occur most often. Any value without its own code is sent as a 6-bit escape prefix followed by its full 16-bit two's-complement value.

Code bits are written into a circular bit store that keeps separate write and read positions. Whenever at least eight bits are held and the byte FIFO has room, the oldest eight bits move into the FIFO as one byte, first bit in the most significant position. The FIFO feeds a valid/ready byte output.

A flush request closes the stream. Input is held off while the flush is pending. The buffered bits are drained, and a final partial byte is completed with zero bits.

Top module: `vlc_byte_packer`

## Requirements
- R1: Coefficient 0 is encoded as the 2-bit code `10`.
- R2: Coefficient +1 is encoded as `1100` and coefficient -1 is encoded as `1101`.
- R3: Coefficient +2 is encoded as `11100` and coefficient -2 is encoded as `11101`.
- R4: Coefficients +3, -3 and -4 are encoded as `111100`, `111101` and `111110` respectively.
- R5: Any other coefficient is encoded as the prefix `111111` followed by its 16-bit two's-complement value, most significant bit first, for 22 bits in total.
- R6: Code bits are concatenated in acceptance order and packed into bytes with the earliest bit at bit 7. A byte moves to the output FIFO in any cycle in which at least 8 bits are buffered and the FIFO is not full. No bit is lost or reordered.
- R7: `coef_ready_o` is low whenever the bit store's free space is below 22 bits. With the default 64-bit store, a 4-byte FIFO and a stalled byte output, exactly four back-to-back escape codes are accepted before input stalls.
- R8: A `flush_i` pulse takes effect after any coefficient accepted in the same cycle. Input is then stalled until the flush completes. A remaining partial byte is emitted padded with zero bits in its low positions. A flush with nothing buffered emits no byte.
- R9: While `byte_valid_o` is high and `byte_ready_i` is low, `byte_valid_o` stays high and `byte_o` stays unchanged.
- R10: After reset, `byte_valid_o` is low and `coef_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coef_valid_i | input | 1 | Coefficient present |
| coef_i | input | 16 | Signed coefficient, two's complement |
| coef_ready_o | output | 1 | Coefficient accepted when high together with valid |
| flush_i | input | 1 | Pulse: pad and emit the last partial byte |
| byte_valid_o | output | 1 | Output byte present |
| byte_o | output | 8 | Packed byte, earliest bit in bit 7 |
| byte_ready_i | input | 1 | Consumer takes the byte when high together with valid |

## Verification
A coefficient accepted at clock edge k is in the bit store after edge k. A byte that completes there enters the FIFO at edge k+1 and shows on `byte_o` from then on, or later if the FIFO is full or bytes are queued ahead of it. Because that delay depends on back-pressure, the bench does not fix an arrival cycle for each byte. It keeps an expected bit queue that it fills at each input handshake and empties eight bits at each output handshake, and it compares every consumed byte against that queue. Handshakes are evaluated one time step after the falling edge on the values the next rising edge will see. The stall count, the held output and the idle flush are checked at fixed cycle counts that follow the register path.

// File: rtl/vlc_pkg.sv
package vlc_pkg;
  localparam int unsigned COEF_W   = 16;
  localparam int unsigned PFX_W    = 6;
  localparam int unsigned MAX_CODE = PFX_W + COEF_W;
  localparam int unsigned LEN_W    = $clog2(MAX_CODE + 1);

  // code left-aligned in bits, first bit sent at MSB
  typedef struct packed {
    logic [MAX_CODE-1:0] bits;
    logic [LEN_W-1:0]    len;
  } code_t;
endpackage

// File: rtl/vlc_code_table.sv
module vlc_code_table
  import vlc_pkg::*;
(
  input  logic [COEF_W-1:0] coef_i,
  output code_t             code_o
);
  logic [PFX_W-1:0] pat;
  logic [LEN_W-1:0] len;
  logic             esc;
  int               val;

  always_comb begin
    val = int'($signed(coef_i));
    esc = 1'b0;
    pat = '0;
    len = '0;
    case (val)
      0:       begin pat = 6'b000010; len = LEN_W'(2); end
      1:       begin pat = 6'b001100; len = LEN_W'(4); end
      -1:      begin pat = 6'b001101; len = LEN_W'(4); end
      2:       begin pat = 6'b011100; len = LEN_W'(5); end
      -2:      begin pat = 6'b011101; len = LEN_W'(5); end
      3:       begin pat = 6'b111100; len = LEN_W'(6); end
      -3:      begin pat = 6'b111101; len = LEN_W'(6); end
      -4:      begin pat = 6'b111110; len = LEN_W'(6); end
      default: esc = 1'b1;
    endcase
  end

  always_comb begin
    if (esc) begin
      code_o.bits = {{PFX_W{1'b1}}, coef_i};
      code_o.len  = LEN_W'(MAX_CODE);
    end else begin
      code_o.bits = MAX_CODE'(pat) << (LEN_W'(MAX_CODE) - len);
      code_o.len  = len;
    end
  end
endmodule

// File: rtl/vlc_bit_ring.sv
module vlc_bit_ring
  import vlc_pkg::*;
#(
  parameter int unsigned RING_BITS = 64,  // power of two
  localparam int unsigned IDX_W    = $clog2(RING_BITS),
  localparam int unsigned CNT_W    = IDX_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [MAX_CODE-1:0] wr_bits_i,
  input  logic [LEN_W-1:0]    wr_len_i,
  input  logic                rd_en_i,
  input  logic                pad_en_i,
  output logic [CNT_W-1:0]    cnt_o,
  output logic [7:0]          byte_o
);
  logic [RING_BITS-1:0] ring;
  logic [IDX_W-1:0]     wr_ptr, rd_ptr;
  logic [CNT_W-1:0]     cnt;

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < int'(MAX_CODE); i++) begin
      if (wr_en_i && (LEN_W'(i) < wr_len_i))
        ring[wr_ptr + IDX_W'(i)] <= wr_bits_i[MAX_CODE-1-i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (wr_en_i) wr_ptr <= wr_ptr + IDX_W'(wr_len_i);
      if (pad_en_i) begin
        rd_ptr <= wr_ptr;
        cnt    <= '0;
      end else begin
        if (rd_en_i) rd_ptr <= rd_ptr + IDX_W'(8);
        cnt <= cnt + (wr_en_i ? CNT_W'(wr_len_i) : '0) - (rd_en_i ? CNT_W'(8) : '0);
      end
    end
  end

  // oldest bit to bit 7; bits past the fill level read as zero
  always_comb begin
    for (int i = 0; i < 8; i++)
      byte_o[7-i] = (CNT_W'(i) < cnt) ? ring[rd_ptr + IDX_W'(i)] : 1'b0;
  end

  assign cnt_o = cnt;
endmodule

// File: rtl/vlc_byte_fifo.sv
module vlc_byte_fifo #(
  parameter int unsigned DEPTH = 4,  // power of two
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  logic [7:0] din_i,
  input  logic       pop_i,
  output logic [7:0] dout_o,
  output logic       full_o,
  output logic       empty_o
);
  logic [7:0]  mem [DEPTH];
  logic [AW:0] wp, rp;

  assign empty_o = (wp == rp);
  assign full_o  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign dout_o  = mem[rp[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) mem[wp[AW-1:0]] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push_i && !full_o) wp <= wp + 1'b1;
      if (pop_i && !empty_o) rp <= rp + 1'b1;
    end
  end
endmodule

// File: rtl/vlc_byte_packer.sv
module vlc_byte_packer
  import vlc_pkg::*;
#(
  parameter int unsigned RING_BITS  = 64,
  parameter int unsigned FIFO_DEPTH = 4,
  localparam int unsigned CNT_W     = $clog2(RING_BITS) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              coef_valid_i,
  input  logic [COEF_W-1:0] coef_i,
  output logic              coef_ready_o,
  input  logic              flush_i,
  output logic              byte_valid_o,
  output logic [7:0]        byte_o,
  input  logic              byte_ready_i
);
  code_t            code;
  logic [CNT_W-1:0] bit_cnt;
  logic [7:0]       ring_byte;
  logic             fifo_full, fifo_empty;
  logic             flush_pend, accept, drain, pad, low_fill;

  vlc_code_table u_table (
    .coef_i (coef_i),
    .code_o (code)
  );

  assign low_fill     = bit_cnt < CNT_W'(8);
  assign coef_ready_o = !flush_pend && (bit_cnt <= CNT_W'(RING_BITS - MAX_CODE));
  assign accept       = coef_valid_i && coef_ready_o;
  assign drain        = !low_fill && !fifo_full;
  assign pad          = flush_pend && low_fill && (bit_cnt != '0) && !fifo_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      flush_pend <= 1'b0;
    else if (flush_i)
      flush_pend <= 1'b1;
    else if (flush_pend && low_fill && ((bit_cnt == '0) || !fifo_full))
      flush_pend <= 1'b0;
  end

  vlc_bit_ring #(.RING_BITS(RING_BITS)) u_ring (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (accept),
    .wr_bits_i (code.bits),
    .wr_len_i  (code.len),
    .rd_en_i   (drain),
    .pad_en_i  (pad),
    .cnt_o     (bit_cnt),
    .byte_o    (ring_byte)
  );

  vlc_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (drain || pad),
    .din_i   (ring_byte),
    .pop_i   (byte_ready_i),
    .dout_o  (byte_o),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  assign byte_valid_o = !fifo_empty;
endmodule

// File: rtl/vlc_packer_sva.sv
module vlc_packer_sva #(
  parameter int unsigned RING_BITS = 64,
  parameter int unsigned CNT_W     = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             coef_ready_o,
  input logic             flush_i,
  input logic             byte_valid_o,
  input logic [7:0]       byte_o,
  input logic             byte_ready_i,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             fifo_full
);
  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt <= CNT_W'(RING_BITS));

  p_flush_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !coef_ready_o);

  p_drain_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_cnt >= CNT_W'(8) && !fifo_full) |=> byte_valid_o);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o && !byte_ready_i) |=> (byte_valid_o && $stable(byte_o)));
endmodule

bind vlc_byte_packer vlc_packer_sva #(.RING_BITS(RING_BITS), .CNT_W(CNT_W)) u_sva (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .coef_ready_o (coef_ready_o),
  .flush_i      (flush_i),
  .byte_valid_o (byte_valid_o),
  .byte_o       (byte_o),
  .byte_ready_i (byte_ready_i),
  .bit_cnt      (bit_cnt),
  .fifo_full    (fifo_full)
);

// File: tb/vlc_byte_packer_test.sv
module vlc_byte_packer_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        coef_valid_i = 1'b0;
  logic [15:0] coef_i = '0;
  logic        coef_ready_o;
  logic        flush_i = 1'b0;
  logic        byte_valid_o;
  logic [7:0]  byte_o;
  logic        byte_ready_i = 1'b0;

  int    total = 0, bad = 0, acc_n = 0;
  bit    finished = 1'b0;
  bit    exp_q[$];
  string req = "R10";

  vlc_byte_packer uut (
    .clk_i(clk), .rst_ni(rst_ni), .coef_valid_i(coef_valid_i), .coef_i(coef_i),
    .coef_ready_o(coef_ready_o), .flush_i(flush_i), .byte_valid_o(byte_valid_o),
    .byte_o(byte_o), .byte_ready_i(byte_ready_i)
  );

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic push_bits(input int pat, input int len);
    for (int i = len - 1; i >= 0; i--) exp_q.push_back(pat[i]);
  endtask

  // expected code per R1..R5
  task automatic push_code(input logic [15:0] c);
    int v;
    v = int'($signed(c));
    case (v)
      0:  push_bits('b10, 2);
      1:  push_bits('b1100, 4);
      -1: push_bits('b1101, 4);
      2:  push_bits('b11100, 5);
      -2: push_bits('b11101, 5);
      3:  push_bits('b111100, 6);
      -3: push_bits('b111101, 6);
      -4: push_bits('b111110, 6);
      default: begin push_bits('b111111, 6); push_bits(int'(c), 16); end
    endcase
  endtask

  task automatic check_byte();
    logic [7:0] e;
    if (exp_q.size() < 8) begin
      chk(1'b0, req, int'(byte_o), exp_q.size());
    end else begin
      for (int i = 7; i >= 0; i--) e[i] = exp_q.pop_front();
      chk(byte_o == e, req, int'(byte_o), int'(e));
    end
  endtask

  task automatic step(input bit cv, input logic [15:0] cd, input bit fl, input bit br);
    @(negedge clk);
    coef_valid_i = cv; coef_i = cd; flush_i = fl; byte_ready_i = br;
    #1;
    if (cv && coef_ready_o) begin push_code(cd); acc_n++; end
    if (fl) while (exp_q.size() % 8 != 0) exp_q.push_back(1'b0);  // R8 padding
    if (byte_valid_o && br) check_byte();
  endtask

  task automatic send(input logic [15:0] cd);
    int g;
    g = 0;
    while (1) begin
      step(1'b1, cd, 1'b0, 1'b1);
      g++;
      if (coef_ready_o || g > 50) break;
    end
  endtask

  task automatic drain_all();
    repeat (40) step(1'b0, '0, 1'b0, 1'b1);
    chk(exp_q.size() == 0, {req, " drained"}, exp_q.size(), 0);
  endtask

  task automatic flush_drain();
    step(1'b0, '0, 1'b1, 1'b1);
    drain_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seen;
    logic [7:0] held;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk(byte_valid_o == 1'b0, "R10 valid", byte_valid_o, 0);
    chk(coef_ready_o == 1'b1, "R10 ready", coef_ready_o, 1);

    req = "R1";  repeat (4) send(16'h0000); drain_all();            // 0xAA
    req = "R2";  send(16'h0001); send(16'hFFFF); drain_all();       // 0xCD
    req = "R3";  send(16'h0002); send(16'hFFFE); flush_drain();
    req = "R4";  send(16'h0003); send(16'hFFFD); send(16'hFFFC); flush_drain();
    req = "R5";  send(16'd100); send(16'hFFFB); send(16'h7FFF); send(16'h8000); flush_drain();
    req = "R8";  send(16'h0000); flush_drain();                     // 0x80

    // R8: flush with nothing buffered emits nothing
    step(1'b0, '0, 1'b1, 1'b1);
    seen = 0;
    repeat (10) begin step(1'b0, '0, 1'b0, 1'b1); if (byte_valid_o) seen++; end
    chk(seen == 0, "R8 empty flush", seen, 0);
    chk(coef_ready_o == 1'b1, "R8 ready after flush", coef_ready_o, 1);

    // R7: stalled output, back-to-back escapes
    req = "R7";
    acc_n = 0;
    repeat (8) step(1'b1, 16'h1234, 1'b0, 1'b0);
    chk(acc_n == 4, "R7 accepts", acc_n, 4);
    chk(coef_ready_o == 1'b0, "R7 stalled", coef_ready_o, 0);
    chk(exp_q.size() == 88, "R7 held bits", exp_q.size(), 88);
    // R9: byte held while not taken
    held = byte_o;
    repeat (3) step(1'b0, '0, 1'b0, 1'b0);
    chk(byte_valid_o && byte_o == held, "R9 hold", int'(byte_o), int'(held));
    req = "R7";
    flush_drain();

    // R6: random mix
    req = "R6";
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] d;
      bit cv, br, fl;
      cv = ($urandom % 10) < 7;
      br = ($urandom % 4) != 0;
      fl = ($urandom % 50) == 0;
      if (($urandom % 5) != 0) d = 16'(int'($urandom % 8) - 4);
      else d = 16'($urandom);
      step(cv, d, fl, br);
    end
    flush_drain();

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule